// File: doc/BRIEF.md
# Linked-List Hardware Queue Manager

This block keeps a set of descriptor queues as singly linked lists threaded through one shared forward-pointer store. Each descriptor index owns exactly one link entry. A queue is described by a head index, a tail index and an entry count held inside the block. The count marks where a list ends, so no terminator is stored. The descriptors themselves and any data movers live outside the block; only indices pass through it.

Several requesters share the block. Each one raises a valid flag together with an operation code, a queue number and an argument, and holds them until its done bit pulses. A round-robin arbiter picks one request at a time. The chosen operation is captured on one clock edge and carried out on the next. The following operations exist: push at the tail, push at the head, pop from the head, clear a queue, and splice a whole queue onto the end of another. Because every request is serialized through the arbiter, producers and consumers need no software locking, even when they share a queue.

When a queue goes from empty to holding entries, the block raises a one-cycle status pulse. It raises a second kind of pulse when a queue's count rises above a programmable threshold. Both pulses carry the number of the affected queue.

Top module: `lqm_mgr`

## Requirements
- R1: Operation code 1 (push tail) appends the argument index to the queue, and successive pops return the indices in the order they were pushed.
- R2: Operation code 2 (push head) inserts the argument index in front of the current head, so that the next pop returns it first.
- R3: Operation code 3 (pop) on a non-empty queue returns the head index on pop_idx_o and removes it. On an empty queue it returns the null index, which is all ones (255 with 256 descriptors), and leaves the queue unchanged.
- R4: No queue has its own length limit: a single queue can hold all NUM_DESC descriptors, and they pop out in order.
- R5: When an operation takes a queue's count from zero to a non-zero value, evt_nonempty_o pulses together with done_o, and evt_qid_o names that queue.
- R6: When an operation takes a queue's count from at most thresh_i to above thresh_i, evt_thresh_o pulses together with done_o, and evt_qid_o names that queue.
- R7: Operation code 4 (clear) empties the queue. A following pop returns the null index, and a following push raises the non-empty event again.
- R8: Operation code 5 (move) takes the destination queue number from the low bits of the argument. It appends the entire source list after the destination's last entry, in constant time, keeping the order, and leaves the source empty. Moving an empty queue, or moving a queue onto itself, changes nothing. Events refer to the destination queue.
- R9: Only one request is served at a time, chosen round-robin, starting from requester 0 after reset and moving past the last winner. done_o is one-hot. It pulses for one cycle, two rising edges after the edge that accepts the request.
- R10: pop_idx_o holds the null index except in the cycle a pop completes on a non-empty queue. Operation codes 0, 6 and 7 complete with no effect on any queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | NUM_REQ | Request valid per requester, held until its done bit |
| req_op_i | input | 3*NUM_REQ | Operation code per requester |
| req_qid_i | input | QW*NUM_REQ | Queue number per requester (source for move) |
| req_arg_i | input | DW*NUM_REQ | Descriptor index to push, or destination queue for move |
| thresh_i | input | CW | Count threshold for the threshold event |
| done_o | output | NUM_REQ | One-hot completion pulse |
| pop_idx_o | output | DW | Popped descriptor index or null |
| evt_nonempty_o | output | 1 | Queue became non-empty |
| evt_thresh_o | output | 1 | Queue count rose above the threshold |
| evt_qid_o | output | QW | Queue the events refer to |

## Verification
Some properties are checked every cycle by the assertions: done_o stays one-hot, it lasts a single cycle, and it follows a held request by exactly two edges. They also check that pop_idx_o rests at the null index between pop completions, and that status pulses appear only with a completion. List contents are a different matter. FIFO and LIFO order, the splicing of whole lists, clearing, a single queue filling every descriptor, the threshold crossing and the round-robin choice between simultaneous requests can only be shown by the bench's scenarios. There, a behavioural queue model predicts every completion.

// File: rtl/lqm_pkg.sv
package lqm_pkg;
  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_PUSH_TAIL = 3'd1,
    OP_PUSH_HEAD = 3'd2,
    OP_POP       = 3'd3,
    OP_CLEAR     = 3'd4,
    OP_MOVE      = 3'd5
  } lqm_op_e;
endpackage

// File: rtl/lqm_rr_arb.sv
module lqm_rr_arb #(
  parameter int N  = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic          gnt_valid_o,
  output logic [IW-1:0] gnt_idx_o
);
  logic [IW-1:0] ptr_q;

  // scan from ptr upward; lowest offset wins
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[(int'(ptr_q) + k) % N]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = IW'((int'(ptr_q) + k) % N);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i && gnt_valid_o)
      ptr_q <= (int'(gnt_idx_o) == N - 1) ? '0 : gnt_idx_o + IW'(1);
  end
endmodule

// File: rtl/lqm_link_ram.sv
module lqm_link_ram #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [AW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [AW-1:0] rdata_o
);
  logic [AW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lqm_mgr.sv
module lqm_mgr
  import lqm_pkg::*;
#(
  parameter int NUM_QUEUES = 32,
  parameter int NUM_DESC   = 256,
  parameter int NUM_REQ    = 2,
  localparam int QW = $clog2(NUM_QUEUES),
  localparam int DW = $clog2(NUM_DESC),
  localparam int CW = $clog2(NUM_DESC + 1),
  localparam int IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_REQ-1:0]    req_valid_i,
  input  logic [3*NUM_REQ-1:0]  req_op_i,
  input  logic [QW*NUM_REQ-1:0] req_qid_i,
  input  logic [DW*NUM_REQ-1:0] req_arg_i,
  input  logic [CW-1:0]         thresh_i,
  output logic [NUM_REQ-1:0]    done_o,
  output logic [DW-1:0]         pop_idx_o,
  output logic                  evt_nonempty_o,
  output logic                  evt_thresh_o,
  output logic [QW-1:0]         evt_qid_o
);
  localparam logic [DW-1:0] NULL_IDX = '1;

  logic          gnt_valid;
  logic [IW-1:0] gnt_idx;

  logic          busy_q;
  logic [IW-1:0] own_q;
  lqm_op_e       op_q;
  logic [QW-1:0] qid_q;
  logic [DW-1:0] arg_q;

  logic [DW-1:0] head_q [NUM_QUEUES];
  logic [DW-1:0] tail_q [NUM_QUEUES];
  logic [CW-1:0] cnt_q  [NUM_QUEUES];

  logic          lw_en;
  logic [DW-1:0] lw_addr, lw_data, lr_data;
  logic [QW-1:0] dst, evq;
  logic [CW-1:0] src_cnt, dst_cnt, old_cnt, new_cnt;
  logic          mv_ok;

  lqm_rr_arb #(.N(NUM_REQ)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_valid_i),
    .adv_i      (!busy_q),
    .gnt_valid_o(gnt_valid),
    .gnt_idx_o  (gnt_idx)
  );

  lqm_link_ram #(.DEPTH(NUM_DESC)) u_link (
    .clk_i  (clk_i),
    .we_i   (lw_en),
    .waddr_i(lw_addr),
    .wdata_i(lw_data),
    .raddr_i(head_q[qid_q]),
    .rdata_o(lr_data)
  );

  assign dst     = arg_q[QW-1:0];
  assign src_cnt = cnt_q[qid_q];
  assign dst_cnt = cnt_q[dst];
  assign mv_ok   = (dst != qid_q) && (src_cnt != '0);

  // link write and count transition of the executing operation
  always_comb begin
    lw_en   = 1'b0;
    lw_addr = '0;
    lw_data = '0;
    evq     = qid_q;
    old_cnt = src_cnt;
    new_cnt = src_cnt;
    case (op_q)
      OP_PUSH_TAIL: begin
        lw_en   = busy_q && (src_cnt != '0);
        lw_addr = tail_q[qid_q];
        lw_data = arg_q;
        new_cnt = src_cnt + CW'(1);
      end
      OP_PUSH_HEAD: begin
        lw_en   = busy_q;
        lw_addr = arg_q;
        lw_data = head_q[qid_q];
        new_cnt = src_cnt + CW'(1);
      end
      OP_POP:   new_cnt = (src_cnt == '0) ? '0 : src_cnt - CW'(1);
      OP_CLEAR: new_cnt = '0;
      OP_MOVE: begin
        lw_en   = busy_q && mv_ok && (dst_cnt != '0);
        lw_addr = tail_q[dst];
        lw_data = head_q[qid_q];
        evq     = dst;
        old_cnt = dst_cnt;
        new_cnt = mv_ok ? dst_cnt + src_cnt : dst_cnt;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q         <= 1'b0;
      own_q          <= '0;
      op_q           <= OP_NOP;
      qid_q          <= '0;
      arg_q          <= '0;
      done_o         <= '0;
      pop_idx_o      <= NULL_IDX;
      evt_nonempty_o <= 1'b0;
      evt_thresh_o   <= 1'b0;
      evt_qid_o      <= '0;
      for (int i = 0; i < NUM_QUEUES; i++) begin
        head_q[i] <= '0;
        tail_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else begin
      done_o         <= busy_q ? (NUM_REQ'(1) << own_q) : '0;
      pop_idx_o      <= (busy_q && op_q == OP_POP && src_cnt != '0) ? head_q[qid_q] : NULL_IDX;
      evt_nonempty_o <= busy_q && (old_cnt == '0) && (new_cnt != '0);
      evt_thresh_o   <= busy_q && (old_cnt <= thresh_i) && (new_cnt > thresh_i);
      evt_qid_o      <= evq;
      if (!busy_q) begin
        if (gnt_valid) begin
          busy_q <= 1'b1;
          own_q  <= gnt_idx;
          op_q   <= lqm_op_e'(req_op_i[int'(gnt_idx)*3 +: 3]);
          qid_q  <= req_qid_i[int'(gnt_idx)*QW +: QW];
          arg_q  <= req_arg_i[int'(gnt_idx)*DW +: DW];
        end
      end else begin
        busy_q <= 1'b0;
        case (op_q)
          OP_PUSH_TAIL: begin
            tail_q[qid_q] <= arg_q;
            if (src_cnt == '0) head_q[qid_q] <= arg_q;
            cnt_q[qid_q] <= new_cnt;
          end
          OP_PUSH_HEAD: begin
            head_q[qid_q] <= arg_q;
            if (src_cnt == '0) tail_q[qid_q] <= arg_q;
            cnt_q[qid_q] <= new_cnt;
          end
          OP_POP: begin
            if (src_cnt != '0) head_q[qid_q] <= lr_data;
            cnt_q[qid_q] <= new_cnt;
          end
          OP_CLEAR: cnt_q[qid_q] <= '0;
          OP_MOVE: begin
            if (mv_ok) begin
              cnt_q[dst]   <= new_cnt;
              cnt_q[qid_q] <= '0;
              tail_q[dst]  <= tail_q[qid_q];
              if (dst_cnt == '0) head_q[dst] <= head_q[qid_q];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lqm_mgr_chk.sv
module lqm_mgr_chk #(
  parameter int NR = 2,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NR-1:0] req_valid_i,
  input logic [NR-1:0] done_o,
  input logic [DW-1:0] pop_idx_o,
  input logic          evt_nonempty_o,
  input logic          evt_thresh_o
);
  AST_DONE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o != '0) |=> (done_o == '0)); // R9
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o != '0) |-> ((done_o & $past(req_valid_i, 2)) == done_o)); // R9
  AST_NULL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o == '0) |-> (pop_idx_o == {DW{1'b1}})); // R10
  AST_NE_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_nonempty_o |-> (done_o != '0)); // R5
  AST_THR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_thresh_o |-> (done_o != '0)); // R6
endmodule

bind lqm_mgr lqm_mgr_chk #(.NR(NUM_REQ), .DW(DW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .done_o        (done_o),
  .pop_idx_o     (pop_idx_o),
  .evt_nonempty_o(evt_nonempty_o),
  .evt_thresh_o  (evt_thresh_o)
);

// File: tb/lqm_mgr_test.sv
module lqm_mgr_test;
  localparam int NQ = 32, ND = 256, NR = 2;
  localparam int QW = 5, DW = 8, CW = 9;
  localparam int NULLI = 255;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NR-1:0] vld = '0;
  logic [3*NR-1:0] op = '0;
  logic [QW*NR-1:0] qid = '0;
  logic [DW*NR-1:0] arg = '0;
  logic [CW-1:0] thr = 9'd2;
  logic [NR-1:0] done;
  logic [DW-1:0] pidx;
  logic ev_ne, ev_th;
  logic [QW-1:0] ev_q;

  lqm_mgr #(.NUM_QUEUES(NQ), .NUM_DESC(ND), .NUM_REQ(NR)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(vld), .req_op_i(op),
    .req_qid_i(qid), .req_arg_i(arg), .thresh_i(thr), .done_o(done),
    .pop_idx_o(pidx), .evt_nonempty_o(ev_ne), .evt_thresh_o(ev_th), .evt_qid_o(ev_q)
  );

  always #5 clk = ~clk;

  int vectors = 0, miscompares = 0, cyc = 0;
  int mq [NQ][$];
  int rr_ptr = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input string rq, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, exp);
    end
  endtask

  task automatic model(input int o, input int q, input int a,
                       output int idx, output int ne, output int th, output int evq);
    int oc, nc, d;
    idx = NULLI; evq = q; oc = mq[q].size(); nc = oc;
    case (o)
      1: begin mq[q].push_back(a); nc = oc + 1; end
      2: begin mq[q].push_front(a); nc = oc + 1; end
      3: begin if (oc > 0) idx = mq[q].pop_front(); nc = mq[q].size(); end
      4: begin mq[q].delete(); nc = 0; end
      5: begin
        d = a % NQ; evq = d; oc = mq[d].size();
        if (d != q && mq[q].size() > 0) begin
          foreach (mq[q][i]) mq[d].push_back(mq[q][i]);
          mq[q].delete();
        end
        nc = mq[d].size();
      end
      default: ;
    endcase
    ne = (oc == 0 && nc > 0) ? 1 : 0;
    th = (oc <= int'(thr) && nc > int'(thr)) ? 1 : 0;
  endtask

  task automatic drive(input int r, input int o, input int q, input int a);
    op[r*3 +: 3]    = 3'(o);
    qid[r*QW +: QW] = QW'(q);
    arg[r*DW +: DW] = DW'(a);
    vld[r] = 1'b1;
  endtask

  task automatic expect_done(input string rq, input int r, input int idx,
                             input int ne, input int th, input int evq);
    chk(rq, "done", int'(done), 1 << r);
    chk(rq, "pop_idx", int'(pidx), idx);
    chk(rq, "evt_nonempty", int'(ev_ne), ne);
    chk(rq, "evt_thresh", int'(ev_th), th);
    if (ne != 0 || th != 0) chk(rq, "evt_qid", int'(ev_q), evq);
  endtask

  // called at a negedge with the block idle
  task automatic issue(input string rq, input int r, input int o, input int q, input int a);
    int idx, ne, th, evq;
    model(o, q, a, idx, ne, th, evq);
    drive(r, o, q, a);
    @(negedge clk);
    chk(rq, "done_capture_cycle", int'(done), 0);
    @(negedge clk);
    expect_done(rq, r, idx, ne, th, evq);
    vld[r] = 1'b0;
    rr_ptr = (r + 1) % NR;
  endtask

  task automatic dual(input string rq, input int o0, input int q0, input int a0,
                      input int o1, input int q1, input int a1);
    int w, l, iw, nw, tw, ew, il, nl, tl, el;
    w = rr_ptr; l = 1 - w;
    if (w == 0) begin
      model(o0, q0, a0, iw, nw, tw, ew); model(o1, q1, a1, il, nl, tl, el);
    end else begin
      model(o1, q1, a1, iw, nw, tw, ew); model(o0, q0, a0, il, nl, tl, el);
    end
    drive(0, o0, q0, a0);
    drive(1, o1, q1, a1);
    @(negedge clk);
    chk(rq, "done_capture_cycle", int'(done), 0);
    @(negedge clk);
    expect_done(rq, w, iw, nw, tw, ew);
    vld[w] = 1'b0;
    @(negedge clk);
    chk(rq, "done_loser_capture", int'(done), 0);
    @(negedge clk);
    expect_done(rq, l, il, nl, tl, el);
    vld[l] = 1'b0;
    rr_ptr = (l + 1) % NR;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10", "reset done", int'(done), 0);
    chk("R10", "reset pop_idx", int'(pidx), NULLI);
    chk("R5", "reset evt_nonempty", int'(ev_ne), 0);
    chk("R6", "reset evt_thresh", int'(ev_th), 0);

    // R1 R5 R6: tail pushes and FIFO order
    issue("R5", 0, 1, 5, 10);
    issue("R1", 0, 1, 5, 11);
    issue("R6", 1, 1, 5, 12);
    issue("R1", 0, 1, 5, 13);
    for (int i = 0; i < 4; i++) issue("R1", i % 2, 3, 5, 0);
    issue("R3", 0, 3, 5, 0);

    // R2: head pushes
    issue("R2", 1, 1, 7, 20);
    issue("R2", 1, 2, 7, 21);
    issue("R2", 0, 2, 7, 22);
    for (int i = 0; i < 3; i++) issue("R2", 0, 3, 7, 0);
    issue("R2", 1, 2, 8, 23);
    issue("R2", 1, 3, 8, 0);

    // R7: clear
    issue("R7", 0, 1, 9, 30);
    issue("R7", 0, 1, 9, 31);
    issue("R7", 0, 4, 9, 0);
    issue("R7", 1, 3, 9, 0);
    issue("R7", 1, 1, 9, 32);
    issue("R7", 1, 3, 9, 0);

    // R8: whole-queue move
    issue("R8", 0, 1, 1, 40);
    issue("R8", 0, 1, 1, 41);
    issue("R8", 0, 1, 2, 50);
    issue("R8", 1, 5, 1, 2);
    issue("R8", 1, 3, 1, 0);
    for (int i = 0; i < 3; i++) issue("R8", 0, 3, 2, 0);
    issue("R8", 0, 5, 2, 3);
    issue("R8", 0, 3, 3, 0);
    issue("R8", 0, 1, 4, 60);
    issue("R8", 1, 1, 4, 61);
    issue("R8", 1, 5, 4, 3);
    issue("R8", 1, 3, 4, 0);
    issue("R8", 0, 3, 3, 0);
    issue("R8", 0, 3, 3, 0);
    issue("R8", 0, 1, 6, 70);
    issue("R8", 0, 5, 6, 6);
    issue("R8", 0, 3, 6, 0);

    // R10: unused codes have no effect
    issue("R10", 0, 1, 10, 90);
    issue("R10", 1, 6, 10, 91);
    issue("R10", 0, 0, 10, 92);
    issue("R10", 0, 3, 10, 0);
    issue("R10", 0, 3, 10, 0);

    // R9: simultaneous requests, round-robin
    dual("R9", 1, 12, 80, 1, 12, 81);
    dual("R9", 1, 12, 82, 1, 13, 83);
    dual("R9", 3, 12, 0, 3, 12, 0);
    dual("R9", 3, 12, 0, 3, 13, 0);

    // R4: one queue holds every descriptor
    thr = 9'd200;
    for (int i = 0; i < ND; i++) issue("R4", i % 2, 1, 11, (i * 37) % ND);
    for (int i = 0; i < ND; i++) issue("R4", 0, 3, 11, 0);
    issue("R4", 1, 3, 11, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule